// File: doc/BRIEF.md
# Byte-Lane Bit Permutation Unit

The unit assembles one byte of an arbitrary 64-bit bit permutation per operation. A 64-bit data word and a 64-bit map word are presented together with a 3-bit lane selector. The map packs eight 6-bit source indices. Each index names the data bit that feeds one bit of the chosen output byte. Every result bit outside that byte is zero.

Software builds a full permutation by issuing the operation once for each of the eight lanes, varying the selector and the map. It then ORs the partial results together. Because the lanes of the partial results never overlap, the OR combination is exact.

The result is held in a single pipeline register. A valid flag travels with it.

Top module: `bperm_lane_unit`

## Requirements
- R1: While rst_ni is low, vld_o and res_o are zero.
- R2: When vld_i is high at a rising clock edge, vld_o is high after that edge. When vld_i is low at a rising clock edge, vld_o is low after that edge. vld_o therefore trails vld_i by exactly one cycle.
- R3: For every j from 0 to 7, result bit 8*lane+j equals data bit map[6j+5:6j]. Here lane is the lane_sel_i value captured with the operands. Index field j of the map occupies bits [6j+5:6j].
- R4: All 56 result bits outside the selected lane are zero. This holds for every lane value from 0 to 7.
- R5: Map bits [63:48] have no effect on the result.
- R6: The result register takes new data only in a cycle where vld_i is high. In a cycle where vld_i is low, res_o keeps its previous value.
- R7: Source indices may repeat. Two or more index fields that hold the same value all copy the same data bit.
- R8: An index may take any value from 0 to 63. Bits 0 and 63 are both reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operands valid |
| data_i | input | 64 | Source word |
| map_i | input | 64 | Packed 6-bit source indices in bits [47:0] |
| lane_sel_i | input | 3 | Destination byte lane |
| vld_o | output | 1 | Result valid |
| res_o | output | 64 | Partial permutation result |

## Verification
The assertions check the result only in the cycle after an accepted operation. They compare it against $past of data_i, map_i and lane_sel_i. For that reason they assume the inputs are known whenever vld_i is high.

The stimulus changes the inputs only between clock edges. It drives fully defined values in every cycle, including the idle cycles in which vld_i is low. Idle cycles also carry different, random operand values, so the hold behaviour of the result register is actually exercised.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  parameter int unsigned DW = 64;
  parameter int unsigned LW = 8;
  localparam int unsigned IW = $clog2(DW);
  localparam int unsigned NL = DW / LW;
  localparam int unsigned SW = $clog2(NL);
  localparam int unsigned MU = LW * IW;
endpackage

// File: rtl/bperm_bit_pick.sv
module bperm_bit_pick
  import bperm_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [MU-1:0] idx_i,
  output logic [LW-1:0] byte_o
);
  for (genvar j = 0; j < LW; j++) begin : g_pick
    logic [IW-1:0] idx;
    assign idx = idx_i[j*IW +: IW];
    assign byte_o[j] = data_i[idx];
  end
endmodule

// File: rtl/bperm_lane_place.sv
module bperm_lane_place
  import bperm_pkg::*;
(
  input  logic [LW-1:0] byte_i,
  input  logic [SW-1:0] lane_i,
  output logic [DW-1:0] word_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign word_o[l*LW +: LW] = (lane_i == SW'(l)) ? byte_i : '0;
  end
  // R4: the selected lane is the only one that can be non-zero
  always_comb begin
    for (int l = 0; l < NL; l++)
      if (lane_i != SW'(l))
        a_lane_zero_r4: assert (word_o[l*LW +: LW] == '0 || $isunknown(lane_i));
  end
endmodule

// File: rtl/bperm_lane_unit.sv
module bperm_lane_unit
  import bperm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [63:0]   data_i,
  input  logic [63:0]   map_i,
  input  logic [2:0]    lane_sel_i,
  output logic          vld_o,
  output logic [63:0]   res_o
);
  logic [LW-1:0] pick_byte;
  logic [DW-1:0] placed;

  bperm_bit_pick i_pick (
    .data_i (data_i),
    .idx_i  (map_i[MU-1:0]),
    .byte_o (pick_byte)
  );

  bperm_lane_place i_place (
    .byte_i (pick_byte),
    .lane_i (lane_sel_i),
    .word_o (placed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= placed;
    end
  end

  p_vld_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  p_vld_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(res_o));
  p_lane_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> ((res_o & ~(64'hFF << (8 * $past(lane_sel_i)))) == 64'd0));
  for (genvar j = 0; j < LW; j++) begin : g_chk
    p_bit_map_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_i |=> res_o[8*$past(lane_sel_i)+j] ==
                $past(data_i[map_i[6*j +: 6]]));
  end
endmodule

// File: tb/test_bperm_lane_unit.sv
module test_bperm_lane_unit;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        vld_i = 0;
  logic [63:0] data_i = 0, map_i = 0;
  logic [2:0]  lane_sel_i = 0;
  logic        vld_o;
  logic [63:0] res_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  bperm_lane_unit i_bperm_lane_unit (.*);

  function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] m,
                                        input logic [2:0] s);
    logic [63:0] r = '0;
    for (int j = 0; j < 8; j++) r[8*s+j] = d[m[6*j +: 6]];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at next negedge (one register)
  task automatic issue(input logic [63:0] d, input logic [63:0] m, input logic [2:0] s,
                       output logic [63:0] r);
    @(negedge clk_i);
    vld_i = 1; data_i = d; map_i = m; lane_sel_i = s;
    @(negedge clk_i);
    vld_i = 0; data_i = $urandom; map_i = {$urandom, $urandom}; lane_sel_i = 3'($urandom);
    r = res_o;
    chk("R2 vld_o", {63'd0, vld_o}, 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 vld_o", {63'd0, vld_o}, 64'd0);
    chk("R1 res_o", res_o, 64'd0);
  endtask

  task automatic t_lanes();
    logic [63:0] r, d, m, full;
    full = '0;
    d = 64'h0123_4567_89AB_CDEF;
    for (int s = 0; s < 8; s++) begin
      m = '0;
      for (int j = 0; j < 8; j++) m[6*j +: 6] = 6'(63 - (8*s + j)); // bit reversal
      issue(d, m, 3'(s), r);
      chk("R3/R4 lane", r, model(d, m, 3'(s)));
      full |= r;
    end
    chk("R3 full reverse", full, {<<{d}});
  endtask

  task automatic t_random();
    logic [63:0] r, d, m;
    for (int k = 0; k < 20; k++) begin
      d = {$urandom, $urandom}; m = {$urandom, $urandom};
      issue(d, m, 3'(k), r);
      chk("R3 random", r, model(d, m, 3'(k)));
    end
  endtask

  task automatic t_upper_ignored();
    logic [63:0] r1, r2, d, m;
    d = 64'hDEAD_BEEF_F00D_CAFE; m = 64'h0000_A5A5_5A5A_1234;
    issue(d, m, 3'd5, r1);
    issue(d, {16'hFFFF, m[47:0]}, 3'd5, r2);
    chk("R5 upper map", r2, r1);
  endtask

  task automatic t_hold();
    logic [63:0] r;
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3'd2, r);
    chk("R7 repeat", r, 64'h0000_0000_00FF_0000);
    @(negedge clk_i);
    chk("R6 hold", res_o, 64'h0000_0000_00FF_0000);
    chk("R2 idle", {63'd0, vld_o}, 64'd0);
  endtask

  task automatic t_edges();
    logic [63:0] r, m;
    m = '0;
    for (int j = 0; j < 8; j++) m[6*j +: 6] = j[0] ? 6'd63 : 6'd0;
    issue(64'h8000_0000_0000_0000, m, 3'd7, r);
    chk("R8 bit63", r, 64'hAA00_0000_0000_0000);
    issue(64'h0000_0000_0000_0001, m, 3'd0, r);
    chk("R8 bit0", r, 64'h0000_0000_0000_0055);
  endtask

  initial begin
    #1 t_reset();
    #20;
    t_reset();
    @(negedge clk_i) rst_ni = 1;
    t_lanes();
    t_random();
    t_upper_ignored();
    t_hold();
    t_edges();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule